// File: doc/BRIEF.md
# CRC-Checked SPI Register Target

This block sits behind an SPI mode 0 port and gives a host byte-wide read and write access to a 128-entry register map that lives in the core. Each access is a short frame, sent most significant bit first. The first byte is a command: its top bit selects the direction and its lower seven bits select the address. The second byte carries the data. On most addresses a third byte carries an 8-bit CRC. The target checks that CRC on writes and computes one for every read reply. One configuration address always uses two-byte frames with no CRC. Bit 0 of the value written there turns CRC checking on or off.

SCLK, CS_n and MOSI are oversampled by the system clock through synchronizers. The register map itself stays in the core, which the target reaches through two ports. Reads use a one-cycle request with a combinational data return. Writes leave through a valid/ready port. A write stays offered, with address and data held, until the core takes it. A write frame that completes while the previous write is still waiting is dropped. A host can also reset the interface by holding CS_n low and sending 64 ones in a row. The target then emits a one-cycle reset pulse so the core can restore its defaults, and it returns its own CRC state to the reset values.

Top module: `spi_crc_regtarget`

## Requirements
- R1: Frames are SPI mode 0. MOSI is sampled on SCLK rising edges and MISO changes after falling edges. Bits run MSB first. In command byte 0, bit 7 = 1 means read, bit 7 = 0 means write, and bits 6:0 are the address. SCLK high and low times are each at least 6 clk cycles.
- R2: While CRC checking is enabled, a write to any address other than 0x5A uses 3 bytes and is accepted only when byte 2 equals the CRC-8 of bytes 0 and 1. The CRC uses polynomial 0x07, initial value 0x00, MSB first. A 2-byte write to such an address is not accepted.
- R3: A CRC-checked write whose CRC does not match is discarded and sets crc_err. crc_err stays set until a soft reset.
- R4: On a read, the target pulses rd_req for one cycle with rd_addr. It takes rd_data in that same cycle. It returns the data on MISO in byte 1 and the CRC-8 of {command, data} in byte 2. MISO is 0 at all other times.
- R5: Address 0x5A is always written with a 2-byte frame and no CRC, whatever the CRC setting. Bit 0 of the value written there enables CRC checking. CRC checking is disabled after reset.
- R6: While CRC checking is disabled, a write to any address is accepted after 16 bits. Any further bits in the same frame are ignored.
- R7: A frame in which CS_n rises before the write's last required bit changes no register.
- R8: An accepted write raises wr_valid. wr_valid, wr_addr and wr_data stay unchanged until wr_ready is seen. A write frame that completes while a write is still pending is dropped.
- R9: 64 consecutive ones counted from the falling edge of CS_n produce exactly one soft_rst pulse, one clk cycle long, per CS_n-low period. Fewer than 64 ones, or a 0 anywhere in the first 64 bits, produce none.
- R10: A soft reset clears crc_err, returns CRC checking to disabled, and drops any pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| rd_req | output | 1 | One-cycle read request to the core |
| rd_addr | output | 7 | Read address, held until the next command |
| rd_data | input | 8 | Core read data, valid in the cycle of rd_req |
| wr_valid | output | 1 | A write is offered to the core |
| wr_ready | input | 1 | Core accepts the offered write |
| wr_addr | output | 7 | Write address |
| wr_data | output | 8 | Write data |
| crc_err | output | 1 | Sticky flag for a CRC mismatch on a write |
| soft_rst | output | 1 | One-cycle pulse when the reset pattern is seen |

## Verification
A soft reset can fall in the same cycle as a write that the core is holding off. In that case the reset must win: the pending write disappears and never reaches the register map. The bench provokes this by holding wr_ready low after a valid write frame and then sending a 64-ones burst. It then judges the result from wr_valid at the port and from the reference register map, which must show the default value at that address once wr_ready is released. A related case is a second write frame that ends while a write is still pending; the bench checks that the first write survives and the second is dropped.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  // One byte through an MSB-first CRC-8 register.
  function automatic logic [BYTE_W-1:0] crc8_byte(input logic [BYTE_W-1:0] seed,
                                                  input logic [BYTE_W-1:0] din,
                                                  input logic [BYTE_W-1:0] poly);
    logic [BYTE_W-1:0] c;
    c = seed;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (c[BYTE_W-1] ^ din[i]) c = {c[BYTE_W-2:0], 1'b0} ^ poly;
      else                      c = {c[BYTE_W-2:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] crc8_pair(input logic [BYTE_W-1:0] b0,
                                                  input logic [BYTE_W-1:0] b1,
                                                  input logic [BYTE_W-1:0] poly);
    return crc8_byte(crc8_byte('0, b0, poly), b1, poly);
  endfunction
endpackage

// File: rtl/spi_crc_sync.sv
module spi_crc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_crc_frame.sv
module spi_crc_frame
  import spi_crc_pkg::*;
#(
  parameter int RESET_ONES = 64,
  localparam int CNT_W = $clog2(RESET_ONES + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic              fall,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              cmd_done,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              b1_done,
  output logic [BYTE_W-1:0] b1,
  output logic              b2_done,
  output logic [BYTE_W-1:0] b2,
  output logic              ones_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              sclk_q;
  logic              rise;
  logic              all_ones;
  logic [BYTE_W-1:0] rx;
  logic [BYTE_W-1:0] rx_nxt;

  assign rise   = sclk_s & ~sclk_q & ~cs_n_s;
  assign fall   = ~sclk_s & sclk_q & ~cs_n_s;
  assign rx_nxt = {rx[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      bit_cnt  <= '0;
      all_ones <= 1'b1;
      rx       <= '0;
      cmd_done <= 1'b0;
      b1_done  <= 1'b0;
      b2_done  <= 1'b0;
      ones_hit <= 1'b0;
      cmd_byte <= '0;
      b1       <= '0;
      b2       <= '0;
    end else begin
      sclk_q   <= sclk_s;
      cmd_done <= 1'b0;
      b1_done  <= 1'b0;
      b2_done  <= 1'b0;
      ones_hit <= 1'b0;
      if (cs_n_s) begin
        bit_cnt  <= '0;
        all_ones <= 1'b1;
      end else if (rise) begin
        rx <= rx_nxt;
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (!mosi_s) all_ones <= 1'b0;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          cmd_done <= 1'b1;
          cmd_byte <= rx_nxt;
        end
        if (bit_cnt == CNT_W'(2 * BYTE_W - 1)) begin
          b1_done <= 1'b1;
          b1      <= rx_nxt;
        end
        if (bit_cnt == CNT_W'(3 * BYTE_W - 1)) begin
          b2_done <= 1'b1;
          b2      <= rx_nxt;
        end
        if (bit_cnt == CNT_W'(RESET_ONES - 1) && all_ones && mosi_s)
          ones_hit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_crc_tx.sv
module spi_crc_tx #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift,
  output logic             miso
);
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clear) sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[WIDTH-2:0], 1'b0};
  end

  assign miso = sr[WIDTH-1];
endmodule

// File: rtl/spi_crc_regtarget.sv
module spi_crc_regtarget
  import spi_crc_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               RESET_ONES  = 64,
  parameter logic [7:0]       CRC_POLY    = 8'h07,
  parameter logic [6:0]       NOCRC_ADDR  = 7'h5A,
  parameter int               CRC_EN_BIT  = 0,
  parameter logic             CRC_EN_RST  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       rd_req,
  output logic [6:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       crc_err,
  output logic       soft_rst
);
  localparam int CNT_W  = $clog2(RESET_ONES + 1) + 1;
  localparam int REPLY_W = 2 * BYTE_W;

  logic              sclk_s, cs_n_s, mosi_s;
  logic              fall, cmd_done, b1_done, b2_done, ones_hit;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] cmd_byte, b1, b2;
  cmd_t              cmd;
  logic              crc_en;
  logic              exempt, commit_raw, commit_chk, crc_ok, commit, slot_free;

  spi_crc_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q({sclk_s, cs_n_s, mosi_s})
  );

  spi_crc_frame #(.RESET_ONES(RESET_ONES)) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .fall(fall), .bit_cnt(bit_cnt), .cmd_done(cmd_done), .cmd_byte(cmd_byte),
    .b1_done(b1_done), .b1(b1), .b2_done(b2_done), .b2(b2), .ones_hit(ones_hit)
  );

  spi_crc_tx #(.WIDTH(REPLY_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(cs_n_s), .load(rd_req),
    .load_val({rd_data, crc8_pair(cmd_byte, rd_data, CRC_POLY)}),
    .shift(fall && bit_cnt > CNT_W'(BYTE_W)), .miso(miso)
  );

  assign cmd        = cmd_t'(cmd_byte);
  assign rd_addr    = cmd.addr;
  assign exempt     = (cmd.addr == NOCRC_ADDR);
  assign crc_ok     = (b2 == crc8_pair(cmd_byte, b1, CRC_POLY));
  assign commit_raw = b1_done && !cmd.rd && (exempt || !crc_en);
  assign commit_chk = b2_done && !cmd.rd && !exempt && crc_en;
  assign commit     = commit_raw || (commit_chk && crc_ok);
  assign slot_free  = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req   <= 1'b0;
      soft_rst <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      crc_en   <= CRC_EN_RST;
      crc_err  <= 1'b0;
    end else begin
      rd_req   <= cmd_done && cmd_byte[BYTE_W-1] == 1'b0 ? 1'b0 : cmd_done;
      soft_rst <= ones_hit;
      if (ones_hit) begin
        wr_valid <= 1'b0;
        crc_en   <= CRC_EN_RST;
        crc_err  <= 1'b0;
      end else begin
        if (wr_valid && wr_ready) wr_valid <= 1'b0;
        if (commit && slot_free) begin
          wr_valid <= 1'b1;
          wr_addr  <= cmd.addr;
          wr_data  <= b1;
          if (exempt) crc_en <= b1[CRC_EN_BIT];
        end
        if (commit_chk && !crc_ok) crc_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_crc_regtarget_chk.sv
module spi_crc_regtarget_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       crc_err,
  input logic       rd_req,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [6:0] wr_addr,
  input logic [7:0] wr_data
);
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> soft_rst || (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R4
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R9
  soft_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R10
  crc_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !crc_err);

  // R10
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !wr_valid);

  // R3
  crc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> crc_err || soft_rst);
endmodule

bind spi_crc_regtarget spi_crc_regtarget_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .crc_err(crc_err), .rd_req(rd_req),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_spi_crc_regtarget.sv
module sim_spi_crc_regtarget;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, rd_req, wr_valid, wr_ready, crc_err, soft_rst;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  always #4 clk = ~clk;

  spi_crc_regtarget u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .crc_err(crc_err),
    .soft_rst(soft_rst)
  );

  int n_cmp = 0, n_bad = 0, rst_seen = 0;
  logic cmp_on = 1'b0;

  logic [7:0] core_mem [128];
  logic [7:0] exp_mem  [128];
  logic       m_crc_en = 1'b0, m_crc_err = 1'b0;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  function automatic logic [7:0] dflt(input int a);
    return 8'((a * 7 + 1) & 255);
  endfunction

  // Long division of {b0,b1,00} by x^8+x^2+x+1
  function automatic logic [7:0] ref_crc(input logic [7:0] b0, input logic [7:0] b1);
    logic [23:0] r;
    r = {b0, b1, 8'h00};
    for (int i = 23; i >= 8; i--) if (r[i]) r[i-:9] = r[i-:9] ^ 9'h107;
    return r[7:0];
  endfunction

  // Core-side register map
  assign rd_data = core_mem[rd_addr];
  always @(posedge clk) begin
    if (soft_rst) begin
      for (int a = 0; a < 128; a++) core_mem[a] <= dflt(a);
    end else if (wr_valid && wr_ready) core_mem[wr_addr] <= wr_data;
    if (soft_rst) rst_seen <= rst_seen + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of the error flag against the model between frames
  always @(negedge clk) if (cmp_on && rst_n) chk("R3 crc_err", crc_err, m_crc_err);

  task automatic xfer(input int nbits);
    cmp_on = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx_buf[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      rx_buf[i/8][7-(i%8)] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int a = 0; a < 128; a++) exp_mem[a] = dflt(a);
    m_crc_en = 1'b0;
    m_crc_err = 1'b0;
  endtask

  task automatic host_write(input logic [6:0] a, input logic [7:0] d, input int nbits,
                            input logic corrupt);
    logic ok;
    tx_buf[0] = {1'b0, a};
    tx_buf[1] = d;
    tx_buf[2] = ref_crc(tx_buf[0], d) ^ (corrupt ? 8'h01 : 8'h00);
    xfer(nbits);
    ok = 1'b0;
    if (a == 7'h5A || !m_crc_en) ok = (nbits >= 16);
    else if (nbits >= 24) begin
      if (corrupt) m_crc_err = 1'b1;
      else         ok = 1'b1;
    end
    if (ok) begin
      exp_mem[a] = d;
      if (a == 7'h5A) m_crc_en = d[0];
    end
    cmp_on = 1'b1;
  endtask

  task automatic host_read(input logic [6:0] a, input int nbits,
                           output logic [7:0] d, output logic [7:0] c);
    tx_buf[0] = {1'b1, a};
    tx_buf[1] = 8'h00;
    tx_buf[2] = 8'h00;
    xfer(nbits);
    d = rx_buf[1];
    c = rx_buf[2];
    cmp_on = 1'b1;
  endtask

  task automatic burst(input int nbits, input logic last_zero);
    for (int i = 0; i < 16; i++) tx_buf[i] = 8'hFF;
    if (last_zero) tx_buf[(nbits-1)/8][7-((nbits-1)%8)] = 1'b0;
    xfer(nbits);
    if (nbits >= 64 && !(last_zero && nbits <= 64)) model_reset();
    cmp_on = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, c;
    int base, mm;
    for (int a = 0; a < 128; a++) core_mem[a] = dflt(a);
    model_reset();
    wr_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R4 miso idle", miso, 0);
    chk("R8 wr_valid idle", wr_valid, 0);
    chk("R3 crc_err reset", crc_err, 0);
    chk("R9 soft_rst idle", soft_rst, 0);
    cmp_on = 1'b1;

    // R6: CRC disabled, 2-byte write accepted
    host_write(7'h10, 8'hA7, 16, 1'b0);
    chk("R6 2-byte write", core_mem[7'h10], 8'hA7);
    // R4 / R1: read back with CRC
    host_read(7'h10, 24, d, c);
    chk("R4 read data", d, 8'hA7);
    chk("R4 read crc", c, ref_crc(8'h90, 8'hA7));
    // R6: extra bits with a wrong CRC are ignored
    host_write(7'h11, 8'h3C, 24, 1'b1);
    chk("R6 trailing bits ignored", core_mem[7'h11], 8'h3C);
    chk("R6 no error", crc_err, 0);

    // R5: enable CRC through the exempt address
    host_write(7'h5A, 8'h01, 16, 1'b0);
    chk("R5 exempt write", core_mem[7'h5A], 8'h01);
    // R2: good CRC write
    host_write(7'h22, 8'h5E, 24, 1'b0);
    chk("R2 crc write", core_mem[7'h22], 8'h5E);
    // R2: 2-byte write refused when CRC is on
    host_write(7'h23, 8'h77, 16, 1'b0);
    chk("R2 short frame refused", core_mem[7'h23], dflt(7'h23));
    // R3: bad CRC
    host_write(7'h24, 8'h12, 24, 1'b1);
    chk("R3 bad crc discarded", core_mem[7'h24], dflt(7'h24));
    chk("R3 crc_err set", crc_err, 1);
    // R7: early chip-select rise
    host_write(7'h25, 8'h34, 20, 1'b0);
    chk("R7 short frame", core_mem[7'h25], dflt(7'h25));
    chk("R3 crc_err sticky", crc_err, 1);
    // R4 / R5 reads
    host_read(7'h22, 24, d, c);
    chk("R4 read data crc on", d, 8'h5E);
    chk("R4 read crc crc on", c, ref_crc(8'hA2, 8'h5E));
    host_read(7'h5A, 16, d, c);
    chk("R5 exempt read", d, 8'h01);

    // R8: back-pressure, and a second write dropped while pending
    wr_ready = 1'b0;
    host_write(7'h30, 8'h99, 24, 1'b0);
    chk("R8 valid held", wr_valid, 1);
    chk("R8 addr held", wr_addr, 7'h30);
    chk("R8 data held", wr_data, 8'h99);
    host_write(7'h31, 8'h44, 24, 1'b0);
    exp_mem[7'h31] = dflt(7'h31);
    chk("R8 first write kept", wr_data, 8'h99);
    @(negedge clk) wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 accepted", core_mem[7'h30], 8'h99);
    chk("R8 second dropped", core_mem[7'h31], dflt(7'h31));

    // R10 / R9: soft reset collides with a pending write
    wr_ready = 1'b0;
    base = rst_seen;
    host_write(7'h40, 8'hEE, 24, 1'b0);
    chk("R8 pending before reset", wr_valid, 1);
    burst(64, 1'b0);
    chk("R10 pending write dropped", wr_valid, 0);
    chk("R9 one pulse", rst_seen - base, 1);
    chk("R10 crc_err cleared", crc_err, 0);
    @(negedge clk) wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 map default", core_mem[7'h40], dflt(7'h40));
    // R10: CRC checking back to disabled
    host_write(7'h41, 8'h5B, 16, 1'b0);
    chk("R10 crc disabled after reset", core_mem[7'h41], 8'h5B);

    // R9: long burst gives one pulse, broken burst none
    base = rst_seen;
    burst(96, 1'b0);
    chk("R9 long burst single pulse", rst_seen - base, 1);
    host_write(7'h42, 8'h66, 16, 1'b0);
    base = rst_seen;
    burst(64, 1'b1);
    chk("R9 63 ones no pulse", rst_seen - base, 0);
    chk("R9 map kept", core_mem[7'h42], 8'h66);

    // Whole map against the model
    mm = 0;
    for (int a = 0; a < 128; a++) if (core_mem[a] !== exp_mem[a]) mm++;
    chk("R2 map matches model", mm, 0);

    cmp_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule